// File: doc/BRIEF.md
# Paged Ethernet Controller Register Bank

This block is the host-facing register bank of a legacy Ethernet controller. A processor reaches it through a byte-wide register bus with a 4-bit offset. Offset 0 always holds the command register. Its two top bits pick one of four register pages, so each of the other fifteen offsets can reach up to four registers. Some offsets reach one register on a write and a different one on a read.

The bank holds the following setup for the rest of the controller:

- the receive ring limits, the boundary and the current receive page;
- the transmit page and the transmit length;
- the remote-DMA start address and byte count;
- the receive and data configuration bytes;
- the interrupt mask;
- the station address and the multicast hash filter.

It keeps the interrupt status byte and drives a level interrupt. A transmit command produces a one-cycle request that carries the transmit page and length to the transmit engine. Writes that would place a ring pointer past the end of packet memory are dropped. A separate reset-access strobe puts the interrupt status back into its power-on state.

Top module: `nic_page_regs`

## Requirements
- R1: After the synchronous reset, the command register reads 0x21 (stop and no-DMA set, page 0) and interrupt status reads 0x80. All other readable registers read 0, and both `irq` and `xmit_req` are low.
- R2: Command bits 7:6 select the page. A register is addressed by the page and the offset together (page*16 + offset). Offset 0 reads and writes the command register on every page.
- R3: A write to page 0 offset 7 clears each status bit 6..0 that is written as 1. Status bit 7 is never cleared by this write.
- R4: `irq` is high exactly when (status AND mask AND 0x7F) is non-zero. The mask is written at page 0 offset 0xF and read back at page 2 offset 0xF. Status bit 7 alone never raises `irq`.
- R5: A command write with bit 0 (stop) clear clears status bit 7. If that write also sets bit 3 or bit 4 (remote read or remote write) while the remote count is 0, status bit 6 (0x40) is set. With a non-zero count, bit 6 is not set.
- R6: A command write with bit 2 set and bit 0 clear starts a transmit. In the next cycle `xmit_req` is high for one cycle and carries the transmit page and the 16-bit length. At the same time the transmit status (page 0 offset 4 read) becomes 0x01, status bit 1 (0x02) is set, and command bit 2 reads back 0. With bit 0 set, no request is made and bit 2 is kept.
- R7: On page 0, offset 4 reads the transmit status but writes the transmit page; the transmit page is read back at page 2 offset 4. Offsets 0xA and 0xB read the constants 0x50 and 0x43 but write the remote count low and high bytes.
- R8: Ring start (page 0 offset 1) and ring stop (page 0 offset 2) writes above the packet-memory end page (0x80) are ignored; both read back at page 2 offsets 1 and 2. Boundary (page 0 offset 3) and current page (page 1 offset 7) writes at or above 0x80 are ignored; each reads back at its own write location.
- R9: Transmit length (page 0 offsets 5/6), remote start address (page 0 offsets 8/9, read back at the same offsets) and remote count (page 0 offsets 0xA/0xB) are written one byte at a time, low byte first in offset order. A byte write changes only its own half.
- R10: Page 1 offsets 1..6 hold the six station address bytes and offsets 8..0xF hold the eight hash filter bytes. All of them can be written and read back.
- R11: Page 0 offsets 0xC and 0xE write the receive and data configuration bytes, read back at page 2 offsets 0xC and 0xE. On page 3, offsets 5 and 6 read 0x40. Every offset with no register behind it reads 0x00.
- R12: A one-cycle `reset_access` strobe sets interrupt status to exactly 0x80 and leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and current page |
| reset_access | input | 1 | Reset-access strobe; restores interrupt status |
| irq | output | 1 | Level interrupt |
| xmit_req | output | 1 | One-cycle transmit request |
| xmit_page | output | 8 | Transmit start page captured with the request |
| xmit_len | output | 16 | Transmit byte count captured with the request |

## Verification
The remote-DMA-complete case is the hardest state to reach. It needs the stop bit clear, a remote read or write request, and a remote count of exactly zero, all in one command write. Because the count is write-only, the only evidence is the status bit. The bench first loads the count halves through the offsets that read back as constant ID bytes. It then issues the command and looks for the status bit. It repeats the command with a non-zero count, and again with the stop bit set, and expects the bit to stay clear in both. The status is cleared through the write-one-to-clear path between steps, so each step begins from a known value.

// File: rtl/nic_page_regs_pkg.sv
package nic_page_regs_pkg;

   // command register bit positions
   localparam int unsigned CB_STOP  = 0;
   localparam int unsigned CB_START = 1;
   localparam int unsigned CB_XMIT  = 2;
   localparam int unsigned CB_RDRD  = 3;
   localparam int unsigned CB_RDWR  = 4;

   // interrupt status bit positions
   localparam int unsigned IB_XMIT  = 1;
   localparam int unsigned IB_RDONE = 6;
   localparam int unsigned IB_RST   = 7;

   localparam logic [7:0] CMD_AT_RESET = 8'h21;
   localparam logic [7:0] ISR_AT_RESET = 8'h80;
   localparam logic [7:0] IRQ_BITS     = 8'h7F;

   typedef enum logic [1:0] {PG_0 = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;

   // {page, offset} register indices
   localparam logic [5:0] IX_RSTART = 6'h01;
   localparam logic [5:0] IX_RSTOP  = 6'h02;
   localparam logic [5:0] IX_BOUND  = 6'h03;
   localparam logic [5:0] IX_XPAGE  = 6'h04;
   localparam logic [5:0] IX_XLEN_L = 6'h05;
   localparam logic [5:0] IX_XLEN_H = 6'h06;
   localparam logic [5:0] IX_STAT   = 6'h07;
   localparam logic [5:0] IX_RADR_L = 6'h08;
   localparam logic [5:0] IX_RADR_H = 6'h09;
   localparam logic [5:0] IX_RCNT_L = 6'h0A;
   localparam logic [5:0] IX_RCNT_H = 6'h0B;
   localparam logic [5:0] IX_RXCFG  = 6'h0C;
   localparam logic [5:0] IX_DCFG   = 6'h0E;
   localparam logic [5:0] IX_MASK   = 6'h0F;
   localparam logic [5:0] IX_STA0   = 6'h11;
   localparam logic [5:0] IX_CUR    = 6'h17;
   localparam logic [5:0] IX_HASH0  = 6'h18;
   localparam logic [5:0] IX_RB_RSTART = 6'h21;
   localparam logic [5:0] IX_RB_RSTOP  = 6'h22;
   localparam logic [5:0] IX_RB_XPAGE  = 6'h24;
   localparam logic [5:0] IX_RB_RXCFG  = 6'h2C;
   localparam logic [5:0] IX_RB_DCFG   = 6'h2E;
   localparam logic [5:0] IX_RB_MASK   = 6'h2F;
   localparam logic [5:0] IX_CFG_A     = 6'h35;
   localparam logic [5:0] IX_CFG_B     = 6'h36;

   function automatic logic [5:0] reg_index(page_e pg, logic [3:0] off);
      return {pg, off};
   endfunction

endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
   import nic_page_regs_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cmd_we,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  rcnt_zero,
   input  logic [DATA_W-1:0]     cur_xpage,
   input  logic [2*DATA_W-1:0]   cur_xlen,
   output logic [DATA_W-1:0]     cmd_q,
   output logic [DATA_W-1:0]     tstat_q,
   output logic                  set_xmit,
   output logic                  set_rdone,
   output logic                  clr_rstflag,
   output logic                  xmit_req,
   output logic [DATA_W-1:0]     xmit_page,
   output logic [2*DATA_W-1:0]   xmit_len
);

   logic running_wr;
   logic fire;
   logic [DATA_W-1:0] cmd_next;

   always_comb begin
      running_wr  = cmd_we && !wdata[CB_STOP];
      fire        = running_wr && wdata[CB_XMIT];
      set_xmit    = fire;
      clr_rstflag = running_wr;
      set_rdone   = running_wr && (wdata[CB_RDRD] || wdata[CB_RDWR]) && rcnt_zero;
      cmd_next    = wdata;
      if (fire) cmd_next[CB_XMIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q     <= CMD_AT_RESET;
         tstat_q   <= '0;
         xmit_req  <= 1'b0;
         xmit_page <= '0;
         xmit_len  <= '0;
      end else begin
         xmit_req <= fire;
         if (cmd_we) cmd_q <= cmd_next;
         if (fire) begin
            tstat_q   <= {{(DATA_W-1){1'b0}}, 1'b1};
            xmit_page <= cur_xpage;
            xmit_len  <= cur_xlen;
         end
      end
   end

   AST_XMIT_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
      fire |=> (!cmd_q[CB_XMIT] && xmit_req && tstat_q == 8'h01)); // R6
   AST_STOPPED_NO_XMIT: assert property (@(posedge clk) disable iff (rst)
      (cmd_we && wdata[CB_STOP]) |=> !xmit_req); // R6

endmodule

// File: rtl/nic_isr_unit.sv
module nic_isr_unit
   import nic_page_regs_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reset_access,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              set_xmit,
   input  logic              set_rdone,
   input  logic              clr_rstflag,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] isr_q,
   output logic              irq
);

   logic [DATA_W-1:0] clr_v, set_v;

   always_comb begin
      clr_v = stat_we ? (wdata & IRQ_BITS) : '0;
      if (clr_rstflag) clr_v[IB_RST] = 1'b1;
      set_v = '0;
      set_v[IB_XMIT]  = set_xmit;
      set_v[IB_RDONE] = set_rdone;
   end

   always_ff @(posedge clk) begin
      if (rst)               isr_q <= ISR_AT_RESET;
      else if (reset_access) isr_q <= ISR_AT_RESET;
      else                   isr_q <= (isr_q & ~clr_v) | set_v;
   end

   assign irq = |(isr_q & mask & IRQ_BITS);

   AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
      (stat_we && !reset_access) |=> ((isr_q & $past(wdata) & IRQ_BITS) == '0)); // R3
   AST_RSTFLAG_CLR: assert property (@(posedge clk) disable iff (rst)
      (clr_rstflag && !reset_access) |=> !isr_q[IB_RST]); // R5
   AST_RDONE_SET: assert property (@(posedge clk) disable iff (rst)
      (set_rdone && !reset_access) |=> isr_q[IB_RDONE]); // R5
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      ((mask & IRQ_BITS) == '0) |-> !irq); // R4
   AST_RESET_ACCESS: assert property (@(posedge clk) disable iff (rst)
      reset_access |=> (isr_q == ISR_AT_RESET)); // R12

endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
   import nic_page_regs_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned MEM_END_PAGE = 128,
   parameter int unsigned STA_BYTES    = 6,
   parameter int unsigned HASH_BYTES   = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [5:0]          idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rstart_q,
   output logic [DATA_W-1:0]   rstop_q,
   output logic [DATA_W-1:0]   bound_q,
   output logic [DATA_W-1:0]   cur_q,
   output logic [DATA_W-1:0]   xpage_q,
   output logic [DATA_W-1:0]   rxcfg_q,
   output logic [DATA_W-1:0]   dcfg_q,
   output logic [DATA_W-1:0]   mask_q,
   output logic [2*DATA_W-1:0] xlen_q,
   output logic [2*DATA_W-1:0] radr_q,
   output logic [2*DATA_W-1:0] rcnt_q,
   output logic [DATA_W-1:0]   sta_q  [STA_BYTES],
   output logic [DATA_W-1:0]   hash_q [HASH_BYTES]
);

   localparam int unsigned NPAIR = 3;
   localparam logic [DATA_W:0] END_PG = (DATA_W+1)'(MEM_END_PAGE);
   localparam logic [5:0] PAIR_LO [NPAIR] = '{IX_XLEN_L, IX_RADR_L, IX_RCNT_L};
   localparam logic [5:0] PAIR_HI [NPAIR] = '{IX_XLEN_H, IX_RADR_H, IX_RCNT_H};

   logic [DATA_W:0] wv;
   logic            fits_incl, fits_excl;
   logic [2*DATA_W-1:0] pair_q [NPAIR];

   assign wv        = {1'b0, wdata};
   assign fits_incl = (wv <= END_PG);
   assign fits_excl = (wv <  END_PG);

   always_ff @(posedge clk) begin
      if (rst) begin
         rstart_q <= '0; rstop_q <= '0; bound_q <= '0; cur_q <= '0;
         xpage_q  <= '0; rxcfg_q <= '0; dcfg_q  <= '0; mask_q <= '0;
      end else if (we) begin
         unique case (idx)
            IX_RSTART: if (fits_incl) rstart_q <= wdata;
            IX_RSTOP:  if (fits_incl) rstop_q  <= wdata;
            IX_BOUND:  if (fits_excl) bound_q  <= wdata;
            IX_CUR:    if (fits_excl) cur_q    <= wdata;
            IX_XPAGE:  xpage_q <= wdata;
            IX_RXCFG:  rxcfg_q <= wdata;
            IX_DCFG:   dcfg_q  <= wdata;
            IX_MASK:   mask_q  <= wdata;
            default: ;
         endcase
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      always_ff @(posedge clk) begin
         if (rst)                          pair_q[p] <= '0;
         else if (we && idx == PAIR_LO[p]) pair_q[p][DATA_W-1:0] <= wdata;
         else if (we && idx == PAIR_HI[p]) pair_q[p][2*DATA_W-1:DATA_W] <= wdata;
      end
   end

   assign xlen_q = pair_q[0];
   assign radr_q = pair_q[1];
   assign rcnt_q = pair_q[2];

   for (genvar s = 0; s < STA_BYTES; s++) begin : g_sta
      always_ff @(posedge clk) begin
         if (rst)                                 sta_q[s] <= '0;
         else if (we && idx == IX_STA0 + 6'(s))   sta_q[s] <= wdata;
      end
   end

   for (genvar h = 0; h < HASH_BYTES; h++) begin : g_hash
      always_ff @(posedge clk) begin
         if (rst)                                 hash_q[h] <= '0;
         else if (we && idx == IX_HASH0 + 6'(h))  hash_q[h] <= wdata;
      end
   end

   AST_BOUND_IN_MEM: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, bound_q} < END_PG) && ({1'b0, cur_q} < END_PG)); // R8
   AST_RING_IN_MEM: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, rstart_q} <= END_PG) && ({1'b0, rstop_q} <= END_PG)); // R8

endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
   import nic_page_regs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned STA_BYTES  = 6,
   parameter int unsigned HASH_BYTES = 8,
   parameter logic [7:0]  ID_LO      = 8'h50,
   parameter logic [7:0]  ID_HI      = 8'h43,
   parameter logic [7:0]  CFG_CONST  = 8'h40
) (
   input  logic [5:0]          idx,
   input  logic [DATA_W-1:0]   cmd_q,
   input  logic [DATA_W-1:0]   isr_q,
   input  logic [DATA_W-1:0]   tstat_q,
   input  logic [DATA_W-1:0]   rstart_q,
   input  logic [DATA_W-1:0]   rstop_q,
   input  logic [DATA_W-1:0]   bound_q,
   input  logic [DATA_W-1:0]   cur_q,
   input  logic [DATA_W-1:0]   xpage_q,
   input  logic [DATA_W-1:0]   rxcfg_q,
   input  logic [DATA_W-1:0]   dcfg_q,
   input  logic [DATA_W-1:0]   mask_q,
   input  logic [2*DATA_W-1:0] radr_q,
   input  logic [DATA_W-1:0]   sta_q  [STA_BYTES],
   input  logic [DATA_W-1:0]   hash_q [HASH_BYTES],
   output logic [DATA_W-1:0]   rdata
);

   always_comb begin
      rdata = '0;
      if (idx[3:0] == 4'h0) begin
         rdata = cmd_q;
      end else begin
         case (idx)
            IX_BOUND:     rdata = bound_q;
            IX_XPAGE:     rdata = tstat_q;
            IX_STAT:      rdata = isr_q;
            IX_RADR_L:    rdata = radr_q[DATA_W-1:0];
            IX_RADR_H:    rdata = radr_q[2*DATA_W-1:DATA_W];
            IX_RCNT_L:    rdata = ID_LO;
            IX_RCNT_H:    rdata = ID_HI;
            IX_CUR:       rdata = cur_q;
            IX_RB_RSTART: rdata = rstart_q;
            IX_RB_RSTOP:  rdata = rstop_q;
            IX_RB_XPAGE:  rdata = xpage_q;
            IX_RB_RXCFG:  rdata = rxcfg_q;
            IX_RB_DCFG:   rdata = dcfg_q;
            IX_RB_MASK:   rdata = mask_q;
            IX_CFG_A:     rdata = CFG_CONST;
            IX_CFG_B:     rdata = CFG_CONST;
            default:      rdata = '0;
         endcase
         for (int s = 0; s < STA_BYTES; s++)
            if (idx == IX_STA0 + 6'(s)) rdata = sta_q[s];
         for (int h = 0; h < HASH_BYTES; h++)
            if (idx == IX_HASH0 + 6'(h)) rdata = hash_q[h];
      end
   end

endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
   import nic_page_regs_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned MEM_END_PAGE = 128,
   parameter int unsigned STA_BYTES    = 6,
   parameter int unsigned HASH_BYTES   = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                reset_access,
   output logic                irq,
   output logic                xmit_req,
   output logic [DATA_W-1:0]   xmit_page,
   output logic [2*DATA_W-1:0] xmit_len
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("nic_page_regs: DATA_W must be 8");
   end
   if (ADDR_W != 4) begin : g_bad_addr_w
      $error("nic_page_regs: ADDR_W must be 4");
   end
   if (MEM_END_PAGE < 1 || MEM_END_PAGE > 255) begin : g_bad_end
      $error("nic_page_regs: MEM_END_PAGE out of range");
   end
   if (STA_BYTES < 1 || STA_BYTES > 6) begin : g_bad_sta
      $error("nic_page_regs: STA_BYTES must be 1..6");
   end
   if (HASH_BYTES < 1 || HASH_BYTES > 8) begin : g_bad_hash
      $error("nic_page_regs: HASH_BYTES must be 1..8");
   end

   logic [DATA_W-1:0]   cmd_q, isr_q, tstat_q;
   logic [DATA_W-1:0]   rstart_q, rstop_q, bound_q, cur_q, xpage_q, rxcfg_q, dcfg_q, mask_q;
   logic [2*DATA_W-1:0] xlen_q, radr_q, rcnt_q;
   logic [DATA_W-1:0]   sta_q  [STA_BYTES];
   logic [DATA_W-1:0]   hash_q [HASH_BYTES];
   logic                set_xmit, set_rdone, clr_rstflag;
   page_e               page;
   logic [5:0]          idx;
   logic                cmd_we, reg_we, stat_we;

   assign page    = page_e'(cmd_q[7:6]);
   assign idx     = reg_index(page, bus_addr);
   assign cmd_we  = bus_we && (bus_addr == '0);
   assign reg_we  = bus_we && (bus_addr != '0);
   assign stat_we = reg_we && (idx == IX_STAT);

   nic_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .wdata(bus_wdata),
      .rcnt_zero(rcnt_q == '0), .cur_xpage(xpage_q), .cur_xlen(xlen_q),
      .cmd_q(cmd_q), .tstat_q(tstat_q), .set_xmit(set_xmit),
      .set_rdone(set_rdone), .clr_rstflag(clr_rstflag),
      .xmit_req(xmit_req), .xmit_page(xmit_page), .xmit_len(xmit_len)
   );

   nic_isr_unit #(.DATA_W(DATA_W)) u_isr (
      .clk(clk), .rst(rst), .reset_access(reset_access), .stat_we(stat_we),
      .wdata(bus_wdata), .set_xmit(set_xmit), .set_rdone(set_rdone),
      .clr_rstflag(clr_rstflag), .mask(mask_q), .isr_q(isr_q), .irq(irq)
   );

   nic_cfg_regs #(.DATA_W(DATA_W), .MEM_END_PAGE(MEM_END_PAGE),
                  .STA_BYTES(STA_BYTES), .HASH_BYTES(HASH_BYTES)) u_cfg (
      .clk(clk), .rst(rst), .we(reg_we), .idx(idx), .wdata(bus_wdata),
      .rstart_q(rstart_q), .rstop_q(rstop_q), .bound_q(bound_q), .cur_q(cur_q),
      .xpage_q(xpage_q), .rxcfg_q(rxcfg_q), .dcfg_q(dcfg_q), .mask_q(mask_q),
      .xlen_q(xlen_q), .radr_q(radr_q), .rcnt_q(rcnt_q),
      .sta_q(sta_q), .hash_q(hash_q)
   );

   nic_read_mux #(.DATA_W(DATA_W), .STA_BYTES(STA_BYTES), .HASH_BYTES(HASH_BYTES)) u_rd (
      .idx(idx), .cmd_q(cmd_q), .isr_q(isr_q), .tstat_q(tstat_q),
      .rstart_q(rstart_q), .rstop_q(rstop_q), .bound_q(bound_q), .cur_q(cur_q),
      .xpage_q(xpage_q), .rxcfg_q(rxcfg_q), .dcfg_q(dcfg_q), .mask_q(mask_q),
      .radr_q(radr_q), .sta_q(sta_q), .hash_q(hash_q), .rdata(bus_rdata)
   );

   AST_REQ_FLAGS_STATUS: assert property (@(posedge clk) disable iff (rst)
      (cmd_we && bus_wdata[CB_XMIT] && !bus_wdata[CB_STOP] && !reset_access)
      |=> (xmit_req && isr_q[IB_XMIT])); // R6

endmodule

// File: tb/nic_page_regs_tb.sv
`timescale 1ns/1ps
module nic_page_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        reset_access = 1'b0;
   logic        irq, xmit_req;
   logic [7:0]  xmit_page;
   logic [15:0] xmit_len;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   nic_page_regs dut_i (
      .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_access(reset_access),
      .irq(irq), .xmit_req(xmit_req), .xmit_page(xmit_page), .xmit_len(xmit_len)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      bus_addr = a;
      #0.5;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic sel_page(input logic [1:0] p);
      wr(4'h0, {p, 6'b100001});
   endtask

   task automatic t_reset;
      rd_chk("R1 cmd", 4'h0, 8'h21);
      rd_chk("R1 status", 4'h7, 8'h80);
      rd_chk("R1 boundary", 4'h3, 8'h00);
      rd_chk("R1 xmit status", 4'h4, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 xmit_req", xmit_req, 1'b0);
   endtask

   task automatic t_split_offsets;
      rd_chk("R7 id lo", 4'hA, 8'h50);
      rd_chk("R7 id hi", 4'hB, 8'h43);
      wr(4'hA, 8'h07);
      rd_chk("R7 id lo after count write", 4'hA, 8'h50);
      wr(4'h4, 8'h45);
      rd_chk("R7 offset4 reads status", 4'h4, 8'h00);
      sel_page(2'd2);
      rd_chk("R7 xmit page readback", 4'h4, 8'h45);
      sel_page(2'd0);
   endtask

   task automatic t_pairs;
      wr(4'h8, 8'h78);
      wr(4'h9, 8'h56);
      rd_chk("R9 radr lo", 4'h8, 8'h78);
      rd_chk("R9 radr hi", 4'h9, 8'h56);
      wr(4'h8, 8'h9A);
      rd_chk("R9 radr hi kept", 4'h9, 8'h56);
      rd_chk("R9 radr lo new", 4'h8, 8'h9A);
   endtask

   task automatic t_range;
      wr(4'h1, 8'h40);
      wr(4'h2, 8'h80);
      wr(4'h2, 8'h81);
      wr(4'h1, 8'h90);
      sel_page(2'd2);
      rd_chk("R8 start kept", 4'h1, 8'h40);
      rd_chk("R8 stop at end accepted", 4'h2, 8'h80);
      sel_page(2'd0);
      wr(4'h3, 8'h7F);
      rd_chk("R8 boundary accepted", 4'h3, 8'h7F);
      wr(4'h3, 8'h80);
      rd_chk("R8 boundary at end ignored", 4'h3, 8'h7F);
      sel_page(2'd1);
      wr(4'h7, 8'h4C);
      rd_chk("R8 current page", 4'h7, 8'h4C);
      wr(4'h7, 8'h80);
      rd_chk("R8 current page at end ignored", 4'h7, 8'h4C);
      sel_page(2'd0);
   endtask

   task automatic t_page1;
      sel_page(2'd1);
      for (int i = 0; i < 6; i++) wr(4'(1 + i), 8'hA0 + 8'(i));
      for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'hC0 + 8'(i));
      for (int i = 0; i < 6; i++) rd_chk("R10 station byte", 4'(1 + i), 8'hA0 + 8'(i));
      for (int i = 0; i < 8; i++) rd_chk("R10 hash byte", 4'(8 + i), 8'hC0 + 8'(i));
      rd_chk("R2 cmd on page 1", 4'h0, 8'h61);
      sel_page(2'd0);
      rd_chk("R2 page0 offset8 is radr", 4'h8, 8'h9A);
      rd_chk("R11 undefined page0 offset1", 4'h1, 8'h00);
   endtask

   task automatic t_page2_3;
      wr(4'hC, 8'h1C);
      wr(4'hE, 8'h49);
      wr(4'hF, 8'h00);
      sel_page(2'd2);
      rd_chk("R11 rx config", 4'hC, 8'h1C);
      rd_chk("R11 data config", 4'hE, 8'h49);
      rd_chk("R4 mask readback", 4'hF, 8'h00);
      rd_chk("R11 undefined page2", 4'h3, 8'h00);
      sel_page(2'd3);
      rd_chk("R11 cfg const a", 4'h5, 8'h40);
      rd_chk("R11 cfg const b", 4'h6, 8'h40);
      rd_chk("R11 undefined page3", 4'h9, 8'h00);
      sel_page(2'd0);
   endtask

   task automatic t_cmd_effects;
      wr(4'hF, 8'hFF);
      #0.5 chk("R4 bit7 alone no irq", irq, 1'b0);
      wr(4'h0, 8'h22);
      rd_chk("R5 reset flag cleared", 4'h7, 8'h00);
      wr(4'hA, 8'h00);
      wr(4'hB, 8'h00);
      wr(4'h0, 8'h0A);
      rd_chk("R5 zero count dma done", 4'h7, 8'h40);
      chk("R4 irq on dma done", irq, 1'b1);
      wr(4'h7, 8'h40);
      rd_chk("R3 dma done cleared", 4'h7, 8'h00);
      chk("R4 irq dropped", irq, 1'b0);
      wr(4'hA, 8'h05);
      wr(4'h0, 8'h12);
      rd_chk("R5 nonzero count no dma done", 4'h7, 8'h00);
      wr(4'hA, 8'h00);
      wr(4'h0, 8'h09);
      rd_chk("R5 stopped no dma done", 4'h7, 8'h00);
   endtask

   task automatic t_xmit;
      wr(4'h5, 8'hEA);
      wr(4'h6, 8'h05);
      wr(4'h0, 8'h26);
      chk("R6 request high", xmit_req, 1'b1);
      chk("R6 request page", xmit_page, 8'h45);
      chk("R9 request length", xmit_len, 16'h05EA);
      rd_chk("R6 cmd xmit bit cleared", 4'h0, 8'h22);
      rd_chk("R6 xmit status", 4'h4, 8'h01);
      rd_chk("R6 status bit", 4'h7, 8'h02);
      chk("R4 irq on xmit", irq, 1'b1);
      @(negedge clk);
      chk("R6 request one cycle", xmit_req, 1'b0);
      wr(4'h7, 8'h02);
      wr(4'h0, 8'h25);
      chk("R6 stopped no request", xmit_req, 1'b0);
      rd_chk("R6 stopped keeps bit", 4'h0, 8'h25);
      rd_chk("R6 stopped no status", 4'h7, 8'h00);
   endtask

   task automatic t_mask_and_reset_access;
      wr(4'h0, 8'h26);
      wr(4'hF, 8'h00);
      #0.5 chk("R4 masked off", irq, 1'b0);
      wr(4'hF, 8'h02);
      #0.5 chk("R4 unmasked", irq, 1'b1);
      wr(4'hF, 8'hFD);
      #0.5 chk("R4 other bits only", irq, 1'b0);
      @(negedge clk);
      reset_access = 1'b1;
      @(negedge clk);
      reset_access = 1'b0;
      rd_chk("R12 status restored", 4'h7, 8'h80);
      wr(4'hF, 8'h80);
      #0.5 chk("R4 bit7 never interrupts", irq, 1'b0);
      wr(4'h7, 8'hFF);
      rd_chk("R3 bit7 not cleared by write", 4'h7, 8'h80);
      sel_page(2'd2);
      rd_chk("R12 xmit page kept", 4'h4, 8'h45);
      rd_chk("R12 rx config kept", 4'hC, 8'h1C);
      sel_page(2'd0);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_split_offsets();
      t_pairs();
      t_range();
      t_page1();
      t_page2_3();
      t_cmd_effects();
      t_xmit();
      t_mask_and_reset_access();
      finish_run();
   end

endmodule